// File: doc/BRIEF.md
# Matrix Keypad Scanner with Key-Valid Strobe

This block scans a 4x4 switch matrix. A rotating one-cold pattern pulls one row line low per clock while the four column lines, pulled high on the board, are sampled. A pressed switch connects the driven row to its column, so that column reads low.

When a low column is seen, the rotation stops on the current row. The row number and the column number are combined into a 4-bit key code, and a registered valid flag rises. The scan stays parked until every column reads high again. The code output is tri-stated whenever the valid flag is low, so several sources can share the code bus. One sample of the columns is the only debounce applied.

Top module: `keypad_scanner`

## Requirements
- R1: After reset the row drive is 4'b1110 (row 0 low), key_valid is 0 and key_code is high-impedance.
- R2: While all columns read 4'hF at a rising edge, the low row moves one place up on that edge (row i to row i+1, and row 3 back to row 0), with exactly one row low at all times.
- R3: At any rising edge where some column reads low, the row drive keeps its value, so the scan stays on the pressed row for as long as the key is held.
- R4: The key code is row*4 + column, with the row index in key_code[3:2] and the column index in key_code[1:0]; row i is the one driven low on row_n[i], and column j is the one reading low on col_n[j].
- R5: key_valid is registered. It is still 0 in the cycle in which a column first reads low, and it is 1 after the next rising edge.
- R6: When every column returns to 4'hF, key_valid stays 1 until the next rising edge and is 0 after it. On that same edge key_code goes high-impedance and the scan resumes.
- R7: If several columns read low at once, the lowest-numbered column is encoded.
- R8: key_code is driven only while key_valid is 1 and is high-impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_n | input | 4 | Column sense lines, low when a switch on the driven row is closed |
| row_n | output | 4 | Row drive, one line low at a time |
| key_code | output | 4 | Encoded key, high-impedance when no key is valid |
| key_valid | output | 1 | High while a detected key is held |

## Verification
The bench models the switch matrix so that a column reads low only while the pressed row is driven. Each key is therefore found at whatever point the scan happens to reach it.

It checks the following corner cases:
- The valid flag is not yet high in the cycle of first detection. A design that made it combinational would show it early.
- The flag and the bus stay up in the half cycle right after release and drop one edge later. A design that dropped them combinationally would lose the code early, and one that waited an extra edge would hold it too long.
- The row drive must not move while a key is held. A scanner that kept rotating would report the wrong row.
- Two columns are pressed together on one row. A design with the wrong priority would encode the higher column.
- A pull-up on the bench side of the code bus turns any stray drive while the flag is low into a visible wrong value.

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int KW = RW + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [COLS-1:0] col_n,
  output logic [ROWS-1:0] row_n,
  output logic [KW-1:0]   key_code,
  output logic            key_valid
);

  logic [ROWS-1:0] ring_q;
  logic            valid_q;
  logic [KW-1:0]   code_q;
  logic [RW-1:0]   row_idx;
  logic [CW-1:0]   col_idx;
  logic            hit;

  assign hit = ~&col_n;

  always_comb begin
    row_idx = '0;
    for (int i = ROWS - 1; i >= 0; i--)
      if (!ring_q[i]) row_idx = RW'(i);
  end

  // descending walk: the lowest low column is assigned last and wins
  always_comb begin
    col_idx = '0;
    for (int j = COLS - 1; j >= 0; j--)
      if (!col_n[j]) col_idx = CW'(j);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q  <= {{(ROWS-1){1'b1}}, 1'b0};
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      if (!hit) ring_q <= {ring_q[ROWS-2:0], ring_q[ROWS-1]};
      valid_q <= hit;
      if (hit && !valid_q) code_q <= {row_idx, col_idx};
    end
  end

  assign row_n     = ring_q;
  assign key_valid = valid_q;
  assign key_code  = valid_q ? code_q : {KW{1'bz}};

  assert_one_row_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_n) == ROWS - 1);

  assert_idle_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&col_n) |=> row_n == {$past(row_n[ROWS-2:0]), $past(row_n[ROWS-1])});

  assert_hold_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&col_n)) |=> $stable(row_n));

  assert_valid_after_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&col_n)) |=> key_valid);

  assert_valid_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && (&col_n)) |=> !key_valid);

endmodule

// File: tb/tb_keypad_scanner.sv
module tb_keypad_scanner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] col_n;
  logic [3:0] row_n;
  tri   [3:0] key_bus;
  logic       key_valid;

  logic       press_on = 1'b0;
  logic [1:0] press_row = '0;
  logic [3:0] press_cols = '0;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pullup pu0 (key_bus[0]);
  pullup pu1 (key_bus[1]);
  pullup pu2 (key_bus[2]);
  pullup pu3 (key_bus[3]);

  always_comb col_n = (press_on && !row_n[press_row]) ? ~press_cols : 4'hF;

  keypad_scanner dut (
    .clk(clk), .rst_n(rst_n), .col_n(col_n),
    .row_n(row_n), .key_code(key_bus), .key_valid(key_valid)
  );

  // press list: {row, column-mask, expected code}
  localparam logic [9:0] VEC [10] = '{
    {2'd0, 4'b0001, 4'd0}, {2'd1, 4'b0100, 4'd6}, {2'd2, 4'b0010, 4'd9},
    {2'd3, 4'b1000, 4'd15}, {2'd0, 4'b1000, 4'd3}, {2'd3, 4'b0001, 4'd12},
    {2'd2, 4'b0100, 4'd10}, {2'd1, 4'b0010, 4'd5},
    {2'd2, 4'b1010, 4'd9}, {2'd1, 4'b1100, 4'd6}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] exp_row;
    repeat (3) @(negedge clk);
    chk(row_n == 4'b1110, "R1 row in reset", row_n, 4'b1110);
    rst_n = 1'b1;
    #1;
    chk(row_n == 4'b1110, "R1 row after reset", row_n, 4'b1110);
    chk(key_valid == 1'b0, "R1 valid after reset", key_valid, 0);
    chk(key_bus === 4'hF, "R1/R8 bus released after reset", key_bus, 4'hF);

    exp_row = 4'b1110;
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      exp_row = {exp_row[2:0], exp_row[3]};
      chk(row_n == exp_row, "R2 idle rotation", row_n, exp_row);
      chk(key_bus === 4'hF && !key_valid, "R8 idle bus", key_bus, 4'hF);
    end

    for (int v = 0; v < 10; v++) begin
      logic [1:0] r;
      logic [3:0] m;
      logic [3:0] code;
      int wt;
      r = VEC[v][9:8];
      m = VEC[v][7:4];
      code = VEC[v][3:0];
      @(negedge clk);
      press_row = r; press_cols = m; press_on = 1'b1;
      #1;
      wt = 0;
      while (col_n == 4'hF && wt < 12) begin
        @(negedge clk); #1; wt++;
      end
      chk(col_n != 4'hF, "R2 scan reaches pressed row", col_n, ~m);
      chk(key_valid == 1'b0, "R5 valid not before edge", key_valid, 0);
      @(negedge clk);
      chk(key_valid == 1'b1, "R5 valid after edge", key_valid, 1);
      if (v >= 8)
        chk(key_bus === code, "R7 lowest column wins", key_bus, code);
      else
        chk(key_bus === code, "R4 key code", key_bus, code);
      for (int h = 0; h < 3; h++) begin
        @(negedge clk);
        chk(row_n == ~(4'b1 << r), "R3 scan frozen", row_n, ~(4'b1 << r));
        chk(key_bus === code, "R4 code held", key_bus, code);
      end
      press_on = 1'b0;
      #1;
      chk(key_valid == 1'b1, "R6 valid until edge", key_valid, 1);
      chk(key_bus === code, "R6 code until edge", key_bus, code);
      @(negedge clk);
      chk(key_valid == 1'b0, "R6 valid cleared", key_valid, 0);
      chk(key_bus === 4'hF, "R6/R8 bus released", key_bus, 4'hF);
      chk(row_n == ~(4'b1 << ((r + 1) % 4)), "R6 scan resumes", row_n,
          ~(4'b1 << ((r + 1) % 4)));
    end

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(row_n == 4'b1110 && !key_valid, "R1 re-reset", row_n, 4'b1110);
    chk(key_bus === 4'hF, "R8 bus in reset", key_bus, 4'hF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule